// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the hardware side of a circular queue of 16-byte transmit descriptors kept in system memory. Software sets up the ring base, the ring size in bytes and a control word through a small word-addressed register port. It then hands descriptors to hardware by moving a tail index forward. The engine owns every slot from its head index up to, but not including, the tail. For each owned slot it issues one memory read for the descriptor and decodes the buffer address, the length and the command byte. A legacy-format descriptor is offered to a downstream frame stage, and the engine waits for that stage's completion report. The engine then writes a status byte back into the slot when the slot asked for it, and steps the head forward, wrapping at the end of the ring.

A descriptor that carries the extended-format flag is never offered downstream. The engine retires it with an error pulse. Status write-back is controlled per descriptor by a report flag, or for all descriptors by a global granularity bit.

Register word map (reg_addr): 0 control (bit 0 transmit enable, bit 1 write back every slot), 1 base low 32 bits, 2 base high 32 bits, 3 ring length in bytes, 4 head index (read only), 5 tail index. The descriptor's bytes are little-endian in rd_rsp_data: bytes 0-7 hold the buffer address, bytes 8-9 the length, byte 10 the checksum offset, byte 11 the command, byte 12 the status, byte 13 the checksum start and bytes 14-15 a special field.

Top module: `txring_engine`

## Requirements
- R1: After reset, the base, length, head, tail and control registers all read 0, and rd_req_valid, tx_valid, wr_valid and desc_err are low.
- R2: A length write drops the low 4 bits of the written value. It is ignored if the value is below 128 or does not fit the length field. An accepted length write clears head and tail to 0.
- R3: A tail write is ignored unless the written value is below length/16.
- R4: A descriptor read is issued only while control bit 0 is set and head differs from tail. Its address is base + 16*head. While control bit 0 is clear, no read is issued and head holds.
- R5: For a descriptor without the extended flag, tx_buf_addr carries bytes 0-7, tx_len carries bytes 8-9 and tx_cmd carries byte 11. tx_eop equals command bit 0, and tx_ins_fcs equals command bit 1 AND command bit 0.
- R6: A descriptor with command bit 5 set is not offered downstream (tx_valid stays low). When head moves past it, desc_err pulses for one cycle.
- R7: If command bit 3 is set or control bit 1 is set, one status write goes to base + 16*head + 12. Its data is {5'b0, late, excess, 1'b1}, with the collision bits taken from the completion report. For an extended-flag descriptor the data is 8'h01.
- R8: If neither command bit 3 nor control bit 1 is set, no status write is made and head advances after completion.
- R9: Head steps by one per retired descriptor and wraps to 0 after index length/16 - 1.
- R10: A tail write in the same cycle as a head advance has both effects take hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Byte address of descriptor |
| rd_rsp_valid | input | 1 | Descriptor data valid |
| rd_rsp_data | input | 128 | Descriptor contents, little-endian |
| tx_valid | output | 1 | Decoded descriptor offered downstream |
| tx_ready | input | 1 | Downstream accepts descriptor |
| tx_buf_addr | output | 64 | Buffer address |
| tx_len | output | 16 | Packet length in bytes |
| tx_cmd | output | 8 | Raw command byte |
| tx_eop | output | 1 | Last descriptor of packet |
| tx_ins_fcs | output | 1 | Insert frame checksum |
| cpl_valid | input | 1 | Downstream completion |
| cpl_excess_col | input | 1 | Completion saw excess collisions |
| cpl_late_col | input | 1 | Completion saw late collision |
| wr_valid | output | 1 | Status write request |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | 64 | Byte address of status byte |
| wr_data | output | 8 | Status byte |
| desc_err | output | 1 | Extended-format descriptor retired |

## Verification
Software may move the tail in the very cycle in which the engine retires a slot and moves the head, so the two register updates collide. The bench provokes this by waiting until the status write is pending, which marks the cycle in which head will advance, and presenting a tail write in that same cycle. It then reads back both indices and requires the head to be one past the retired slot and the tail to hold the newly written value.

// File: rtl/txr_pkg.sv
// Package: shared constants and types for the transmit ring engine.
// Assumes little-endian 16-byte descriptors and word-indexed registers.
package txr_pkg;
    localparam int DESC_BYTES = 16;
    localparam int PTR_W      = 64;
    localparam int STAT_OFS   = 12;
    localparam int MIN_RING   = 128;

    // register word indices
    localparam logic [3:0] RG_CTRL    = 4'd0;
    localparam logic [3:0] RG_BASE_LO = 4'd1;
    localparam logic [3:0] RG_BASE_HI = 4'd2;
    localparam logic [3:0] RG_LEN     = 4'd3;
    localparam logic [3:0] RG_HEAD    = 4'd4;
    localparam logic [3:0] RG_TAIL    = 4'd5;

    // control bits
    localparam int CT_EN   = 0;
    localparam int CT_GRAN = 1;

    // command byte bits
    localparam int CB_EOP  = 0;
    localparam int CB_FCS  = 1;
    localparam int CB_RS   = 3;
    localparam int CB_EXT  = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_WAIT, S_SEND, S_CPL, S_WB
    } fsm_t;

    typedef struct packed {
        logic [PTR_W-1:0] addr;
        logic [15:0]      len;
        logic [7:0]       cmd;
    } desc_t;
endpackage

// File: rtl/txr_regs.sv
// Module: txr_regs
// Register file for the ring: control, base, length, head and tail.
// Assumes head_adv is only raised while the ring is non-empty.
module txr_regs
    import txr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              head_adv,
    output logic              enable,
    output logic              gran,
    output logic [PTR_W-1:0]  base,
    output logic [IDX_W-1:0]  count,
    output logic [IDX_W-1:0]  head,
    output logic [IDX_W-1:0]  tail
);
    localparam int LEN_W = IDX_W + 4;

    logic [LEN_W-1:0] len_q;
    logic             len_ok;
    logic             tail_ok;
    logic             wr_len;
    logic [IDX_W-1:0] head_next;

    assign count   = len_q[LEN_W-1:4];
    assign len_ok  = ((reg_wdata >> LEN_W) == 32'd0) &&
                     (reg_wdata[LEN_W-1:0] >= LEN_W'(MIN_RING));
    assign tail_ok = reg_wdata < 32'(count);
    assign wr_len  = reg_wr && reg_addr == RG_LEN && len_ok;

    // next head index with wrap at the ring end
    always_comb begin
        if (head == count - 1'b1) head_next = '0;
        else                      head_next = head + 1'b1;
    end

    // control, base and length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            gran   <= 1'b0;
            base   <= '0;
            len_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RG_CTRL: begin
                    enable <= reg_wdata[CT_EN];
                    gran   <= reg_wdata[CT_GRAN];
                end
                RG_BASE_LO: base[31:0]  <= reg_wdata;
                RG_BASE_HI: base[63:32] <= reg_wdata;
                RG_LEN: if (len_ok) len_q <= {reg_wdata[LEN_W-1:4], 4'b0};
                default: ;
            endcase
        end
    end

    // head index: cleared by length write, else stepped by the engine
    always_ff @(posedge clk) begin
        if (!rst_n)        head <= '0;
        else if (wr_len)   head <= '0;
        else if (head_adv) head <= head_next;
    end

    // tail index: cleared by length write, else software-written when in range
    always_ff @(posedge clk) begin
        if (!rst_n)      tail <= '0;
        else if (wr_len) tail <= '0;
        else if (reg_wr && reg_addr == RG_TAIL && tail_ok)
            tail <= reg_wdata[IDX_W-1:0];
    end

    // read multiplexer
    always_comb begin
        case (reg_addr)
            RG_CTRL:    reg_rdata = {30'd0, gran, enable};
            RG_BASE_LO: reg_rdata = base[31:0];
            RG_BASE_HI: reg_rdata = base[63:32];
            RG_LEN:     reg_rdata = 32'(len_q);
            RG_HEAD:    reg_rdata = 32'(head);
            RG_TAIL:    reg_rdata = 32'(tail);
            default:    reg_rdata = 32'd0;
        endcase
    end

    // R3 / R9: indices stay inside the ring
    p_tail_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (tail < count));
    p_head_in_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (head < count));
    // R9: head steps by exactly one or wraps to zero
    p_head_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (head_adv && !wr_len) |=> (head == '0 || head == IDX_W'($past(head) + 1'b1)));
endmodule

// File: rtl/txr_decode.sv
// Module: txr_decode
// Splits a raw 16-byte descriptor into fields and checks legacy format.
// Purely combinational; assumes little-endian byte order.
module txr_decode
    import txr_pkg::*;
(
    input  logic [8*DESC_BYTES-1:0] raw,
    output desc_t                   fields,
    output logic                    legacy_ok,
    output logic                    report_req
);
    logic unused_bytes;

    // field extraction: bytes 0-7 address, 8-9 length, 11 command
    always_comb begin
        fields.addr = raw[63:0];
        fields.len  = raw[79:64];
        fields.cmd  = raw[95:88];
    end

    assign legacy_ok    = ~raw[88 + CB_EXT];
    assign report_req   = raw[88 + CB_RS];
    assign unused_bytes = ^{raw[127:96], raw[87:80]};
endmodule

// File: rtl/txr_ctrl.sv
// Module: txr_ctrl
// Sequencer: fetches the head descriptor, offers it downstream, waits for
// completion, writes status back and retires the slot. Assumes base is
// 16-byte aligned and registers are not rewritten while a slot is in flight.
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    gran,
    input  logic [PTR_W-1:0]        base,
    input  logic [IDX_W-1:0]        count,
    input  logic [IDX_W-1:0]        head,
    input  logic [IDX_W-1:0]        tail,
    output logic                    rd_req_valid,
    input  logic                    rd_req_ready,
    output logic [PTR_W-1:0]        rd_req_addr,
    input  logic                    rd_rsp_valid,
    input  logic [8*DESC_BYTES-1:0] rd_rsp_data,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [PTR_W-1:0]        tx_buf_addr,
    output logic [15:0]             tx_len,
    output logic [7:0]              tx_cmd,
    output logic                    tx_eop,
    output logic                    tx_ins_fcs,
    input  logic                    cpl_valid,
    input  logic                    cpl_excess_col,
    input  logic                    cpl_late_col,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [PTR_W-1:0]        wr_addr,
    output logic [7:0]              wr_data,
    output logic                    head_adv,
    output logic                    desc_err
);
    fsm_t             state, state_d;
    desc_t            dec, cur;
    logic             dec_legacy, dec_rs;
    logic             err_q, rs_q;
    logic [7:0]       stat_q;
    logic             capture, adv_err, load_cpl, load_ext;
    logic [PTR_W-1:0] slot_addr;

    txr_decode u_dec (
        .raw        (rd_rsp_data),
        .fields     (dec),
        .legacy_ok  (dec_legacy),
        .report_req (dec_rs)
    );

    assign slot_addr    = base + (PTR_W'(head) << 4);
    assign rd_req_addr  = slot_addr;
    assign wr_addr      = slot_addr + PTR_W'(STAT_OFS);
    assign rd_req_valid = (state == S_REQ);
    assign tx_valid     = (state == S_SEND);
    assign wr_valid     = (state == S_WB);
    assign wr_data      = stat_q;
    assign tx_buf_addr  = cur.addr;
    assign tx_len       = cur.len;
    assign tx_cmd       = cur.cmd;
    assign tx_eop       = cur.cmd[CB_EOP];
    assign tx_ins_fcs   = cur.cmd[CB_EOP] & cur.cmd[CB_FCS];

    // next-state, retire and capture decisions
    always_comb begin
        state_d  = state;
        head_adv = 1'b0;
        adv_err  = 1'b0;
        capture  = 1'b0;
        load_cpl = 1'b0;
        load_ext = 1'b0;
        case (state)
            S_IDLE: if (enable && count != '0 && head != tail) state_d = S_REQ;
            S_REQ:  if (rd_req_ready) state_d = S_WAIT;
            S_WAIT: if (rd_rsp_valid) begin
                capture = 1'b1;
                if (!dec_legacy) begin
                    load_ext = 1'b1;
                    if (dec_rs || gran) state_d = S_WB;
                    else begin
                        head_adv = 1'b1;
                        adv_err  = 1'b1;
                        state_d  = S_IDLE;
                    end
                end else state_d = S_SEND;
            end
            S_SEND: if (tx_ready) state_d = S_CPL;
            S_CPL:  if (cpl_valid) begin
                load_cpl = 1'b1;
                if (rs_q || gran) state_d = S_WB;
                else begin
                    head_adv = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_WB:   if (wr_ready) begin
                head_adv = 1'b1;
                adv_err  = err_q;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            desc_err <= 1'b0;
        end else begin
            state    <= state_d;
            desc_err <= head_adv && adv_err;
        end
    end

    // descriptor capture and status byte assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            err_q  <= 1'b0;
            rs_q   <= 1'b0;
            stat_q <= 8'd0;
        end else begin
            if (capture) begin
                cur   <= dec;
                err_q <= ~dec_legacy;
                rs_q  <= dec_rs;
            end
            if (load_ext) stat_q <= 8'h01;
            if (load_cpl) stat_q <= {5'd0, cpl_late_col, cpl_excess_col, 1'b1};
        end
    end

    // R4: a pending read holds its address until accepted
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
    // R4: a read starts only when enabled and the ring holds work
    p_fetch_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_valid) |-> (enable && head != tail));
    // R6: an extended-format descriptor is never offered downstream
    p_ext_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && rd_rsp_valid && rd_rsp_data[88 + CB_EXT]) |=> !tx_valid);
    // R7: every status write carries the done bit
    p_wb_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[0]);
    // R5: offered fields stay stable until accepted
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_buf_addr) && $stable(tx_len)));
endmodule

// File: rtl/txring_engine.sv
// Module: txring_engine
// Top of the transmit descriptor ring engine: joins the register file and
// the sequencer. Assumes one memory read in flight at a time.
module txring_engine
    import txr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [3:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    rd_req_valid,
    input  logic                    rd_req_ready,
    output logic [PTR_W-1:0]        rd_req_addr,
    input  logic                    rd_rsp_valid,
    input  logic [8*DESC_BYTES-1:0] rd_rsp_data,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [PTR_W-1:0]        tx_buf_addr,
    output logic [15:0]             tx_len,
    output logic [7:0]              tx_cmd,
    output logic                    tx_eop,
    output logic                    tx_ins_fcs,
    input  logic                    cpl_valid,
    input  logic                    cpl_excess_col,
    input  logic                    cpl_late_col,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [PTR_W-1:0]        wr_addr,
    output logic [7:0]              wr_data,
    output logic                    desc_err
);
    logic             enable, gran, head_adv;
    logic [PTR_W-1:0] base;
    logic [IDX_W-1:0] count, head, tail;

    txr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .head_adv  (head_adv),
        .enable    (enable),
        .gran      (gran),
        .base      (base),
        .count     (count),
        .head      (head),
        .tail      (tail)
    );

    txr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .gran           (gran),
        .base           (base),
        .count          (count),
        .head           (head),
        .tail           (tail),
        .rd_req_valid   (rd_req_valid),
        .rd_req_ready   (rd_req_ready),
        .rd_req_addr    (rd_req_addr),
        .rd_rsp_valid   (rd_rsp_valid),
        .rd_rsp_data    (rd_rsp_data),
        .tx_valid       (tx_valid),
        .tx_ready       (tx_ready),
        .tx_buf_addr    (tx_buf_addr),
        .tx_len         (tx_len),
        .tx_cmd         (tx_cmd),
        .tx_eop         (tx_eop),
        .tx_ins_fcs     (tx_ins_fcs),
        .cpl_valid      (cpl_valid),
        .cpl_excess_col (cpl_excess_col),
        .cpl_late_col   (cpl_late_col),
        .wr_valid       (wr_valid),
        .wr_ready       (wr_ready),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .head_adv       (head_adv),
        .desc_err       (desc_err)
    );

    // R1: no outward request is raised while in reset
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!rd_req_valid && !tx_valid && !wr_valid));
endmodule

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
    import txr_pkg::*;

    localparam logic [63:0] BASE  = 64'h0000_0001_2345_6700;
    localparam int          SLOTS = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = 4'd0;
    logic [31:0]  reg_wdata = 32'd0;
    logic [31:0]  reg_rdata;
    logic         rd_req_valid, rd_req_ready = 1'b1;
    logic [63:0]  rd_req_addr;
    logic         rd_rsp_valid = 1'b0;
    logic [127:0] rd_rsp_data = '0;
    logic         tx_valid, tx_ready = 1'b1;
    logic [63:0]  tx_buf_addr;
    logic [15:0]  tx_len;
    logic [7:0]   tx_cmd;
    logic         tx_eop, tx_ins_fcs;
    logic         cpl_valid = 1'b0, cpl_excess_col = 1'b0, cpl_late_col = 1'b0;
    logic         wr_valid, wr_ready = 1'b1;
    logic [63:0]  wr_addr;
    logic [7:0]   wr_data;
    logic         desc_err;

    int tests = 0;
    int fails = 0;
    int exp_head = 0;

    always #2 clk = ~clk;

    txring_engine u0 (.*);

    // vector: addr, len, cmd, excess, late, gran
    localparam logic [90:0] VEC [10] = '{
        {64'h0000_0000_0000_1000, 16'd64,   8'h0B, 1'b0, 1'b0, 1'b0},
        {64'h0000_0000_0000_2000, 16'd100,  8'h03, 1'b0, 1'b0, 1'b0},
        {64'h0000_0000_0000_3000, 16'd1500, 8'h09, 1'b1, 1'b0, 1'b0},
        {64'h0000_0000_0000_4000, 16'd60,   8'h01, 1'b0, 1'b1, 1'b1},
        {64'h0000_0000_0000_5000, 16'd80,   8'h20, 1'b0, 1'b0, 1'b0},
        {64'h0000_0000_0000_6000, 16'd90,   8'h28, 1'b0, 1'b0, 1'b0},
        {64'h0000_0000_0000_7000, 16'd70,   8'h02, 1'b0, 1'b0, 1'b0},
        {64'h0000_00AB_CDEF_8000, 16'd1514, 8'h0B, 1'b1, 1'b1, 1'b0},
        {64'h0000_0000_0000_9000, 16'd66,   8'h00, 1'b0, 1'b0, 1'b1},
        {64'h0000_0000_0000_A000, 16'd77,   8'h21, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // serve one owned slot as memory, frame stage and write port
    task automatic serve(input logic [90:0] v, input bit collide,
                         input logic [31:0] new_tail);
        logic [63:0] a;  logic [15:0] l;  logic [7:0] c;
        logic exc, lt, g, send, rep, seen_wr, seen_err, seen_tx;
        logic [7:0] wd, wdv;  logic [63:0] wa;  int nh;
        a = v[90:27]; l = v[26:11]; c = v[10:3]; exc = v[2]; lt = v[1]; g = v[0];
        send = !c[CB_EXT];
        rep  = c[CB_RS] | g;
        wd   = c[CB_EXT] ? 8'h01 : {5'd0, lt, exc, 1'b1};
        nh   = (exp_head + 1) % SLOTS;
        seen_wr = 0; seen_err = 0; seen_tx = 0; wa = '0; wdv = '0;
        @(negedge clk);
        for (int n = 0; n < 50 && !rd_req_valid; n++) @(negedge clk);
        chk(rd_req_valid && rd_req_addr == BASE + 64'(16 * exp_head),
            "R4 read address", rd_req_addr, BASE + 64'(16 * exp_head));
        @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = {16'h5A5A, 8'h11, 8'hEE, c, 8'h22, l, a};
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        if (send) begin
            chk(tx_valid && tx_buf_addr == a && tx_len == l && tx_cmd == c,
                "R5 fields", {tx_buf_addr[31:0], tx_len, tx_cmd}, {a[31:0], l, c});
            chk(tx_eop == c[0] && tx_ins_fcs == (c[0] & c[1]), "R5 eop/fcs",
                {tx_eop, tx_ins_fcs}, {c[0], c[0] & c[1]});
            @(negedge clk);
            cpl_valid = 1'b1; cpl_excess_col = exc; cpl_late_col = lt;
            @(negedge clk);
            cpl_valid = 1'b0; cpl_excess_col = 1'b0; cpl_late_col = 1'b0;
        end
        reg_addr = RG_HEAD;
        #1;
        for (int k = 0; k < 12; k++) begin
            if (desc_err) seen_err = 1;
            if (tx_valid) seen_tx = 1;
            if (reg_rdata == 32'(nh)) break;
            if (wr_valid) begin
                seen_wr = 1; wa = wr_addr; wdv = wr_data;
                if (collide) begin
                    reg_wr = 1'b1; reg_addr = RG_TAIL; reg_wdata = new_tail;
                end
            end
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = RG_HEAD;
            #1;
        end
        chk(reg_rdata == 32'(nh), nh == 0 ? "R9 head wrap" : "R9 head step",
            reg_rdata, nh);
        chk(seen_wr == rep, rep ? "R7 write made" : "R8 no write", seen_wr, rep);
        if (rep) chk(wa == BASE + 64'(16 * exp_head + 12) && wdv == wd,
                     "R7 status write", {wa[31:0], wdv},
                     {BASE[31:0] + 32'(16 * exp_head + 12), wd});
        chk(seen_err == c[CB_EXT], "R6 error pulse", seen_err, c[CB_EXT]);
        if (!send) chk(!seen_tx, "R6 not offered", seen_tx, 0);
        exp_head = nh;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic any_req;
        repeat (3) @(negedge clk);
        chk(!rd_req_valid && !tx_valid && !wr_valid && !desc_err,
            "R1 outputs in reset", {rd_req_valid, tx_valid, wr_valid, desc_err}, 0);
        rst_n = 1'b1;
        for (int r = 0; r < 6; r++) begin
            reg_read(4'(r), d);
            chk(d == 0, "R1 register reset", d, 0);
        end
        // table-driven setup of the ring
        reg_write(RG_BASE_LO, BASE[31:0]);
        reg_write(RG_BASE_HI, BASE[63:32]);
        reg_write(RG_LEN, 32'd100);
        reg_read(RG_LEN, d);
        chk(d == 0, "R2 short length ignored", d, 0);
        reg_write(RG_LEN, 32'h0001_0000);
        reg_read(RG_LEN, d);
        chk(d == 0, "R2 oversize length ignored", d, 0);
        reg_write(RG_LEN, 32'h85);
        reg_read(RG_LEN, d);
        chk(d == 32'h80, "R2 low bits dropped", d, 32'h80);
        reg_write(RG_TAIL, 32'd8);
        reg_read(RG_TAIL, d);
        chk(d == 0, "R3 tail beyond ring ignored", d, 0);
        reg_write(RG_TAIL, 32'd3);
        reg_read(RG_TAIL, d);
        chk(d == 3, "R3 tail in ring accepted", d, 3);
        // enable clear: no fetch, head holds
        any_req = 0;
        for (int w = 0; w < 10; w++) begin
            @(negedge clk);
            if (rd_req_valid) any_req = 1;
        end
        chk(!any_req, "R4 no fetch while disabled", any_req, 0);
        reg_read(RG_HEAD, d);
        chk(d == 0, "R4 head holds while disabled", d, 0);
        reg_write(RG_LEN, 32'h90);
        reg_read(RG_TAIL, d);
        chk(d == 0, "R2 length write clears tail", d, 0);
        reg_write(RG_LEN, 32'h80);
        // walk the vector table, one owned slot each
        foreach (VEC[i]) begin
            reg_write(RG_CTRL, {30'd0, VEC[i][0], 1'b1});
            reg_write(RG_TAIL, 32'((exp_head + 1) % SLOTS));
            serve(VEC[i], 1'b0, 32'd0);
        end
        // R10: tail write in the same cycle as the head advance
        reg_write(RG_CTRL, 32'h1);
        reg_write(RG_TAIL, 32'((exp_head + 1) % SLOTS));
        serve({64'h0000_0000_0000_B000, 16'd88, 8'h09, 1'b0, 1'b0, 1'b0}, 1'b1, 32'd6);
        reg_read(RG_TAIL, d);
        chk(d == 6, "R10 tail taken with head advance", d, 6);
        reg_read(RG_HEAD, d);
        chk(d == 32'(exp_head), "R10 head taken with tail write", d, exp_head);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule